// File: doc/BRIEF.md
# Burst-capable ROM read controller

This block connects a CPU-side read port to a 16-bit external ROM that can return consecutive words quickly once the first word has been fetched. Reads that fall inside one aligned address area are decoded. The controller opens each run with a full initial access. For consecutive instruction fetches that stay inside an aligned group of 4 or 8 halfwords, it then issues shortened burst cycles. It drives the ROM address, an active-low chip-select and an active-low read strobe. It captures the 16-bit word and returns it to the requester with a one-cycle ready pulse.

Four run-time configuration inputs control the behaviour. One enables burst mode. One picks the group size. One picks the burst-cycle length. One picks the initial-cycle length and whether that cycle honours the wait input. Each request is a one-cycle strobe. The next request may be issued in the cycle where ready is high, or in any later cycle. A request issued in the ready cycle is the only kind that can continue a burst.

Top module: `brom_ctrl`

## Requirements
- R1: A request that finds the controller idle returns its word T+1 cycles after the request cycle. T is 2 when `cfg_long_init` is 0 and 3 when it is 1. `rdata` equals the ROM word at the halfword address (bit 0 of the address ignored).
- R2: With `cfg_long_init` = 1, each cycle that `wait_n` is low in the last initial state adds one state. Earlier states ignore it. With `cfg_long_init` = 0, `wait_n` has no effect.
- R3: A fetch (`req_fetch` = 1) issued in the ready cycle of a previous fetch continues the burst when all of these hold: burst mode was enabled at the run's full access, the address is the previous one plus 2, and it stays in the same aligned group. It then returns B+1 cycles later, where B is 1 when `cfg_slow_burst` = 0 and 2 when it is 1.
- R4: The aligned group is 8 bytes (4 words) when `cfg_run8` = 0 and 16 bytes (8 words) when it is 1. A sequential fetch whose address is a multiple of the group size starts a new full access.
- R5: `wait_n` has no effect during burst cycles.
- R6: A request in the ready cycle that does not continue a burst gets a full access after one cycle with chip-select high, with latency T+2 (+ waits). This covers a data read, burst mode disabled, a non-sequential address, or a group crossing.
- R7: `rom_rd_n` equals `rom_cs_n`. Chip-select is low from the first access state through the ready cycle, stays low across burst cycles, and is high in the cycle after a ready cycle that carries no new request.
- R8: The configuration inputs are sampled only when a full access begins. Changes during a burst do not alter that burst's cycle length or group size.
- R9: `rdy` is a single-cycle pulse, one per accepted request.
- R10: A request outside the area `[AREA_BASE, AREA_BASE + 2^AREA_LG)` is ignored: no ready, and chip-select stays high.
- R11: A fetch issued after an idle cycle always gets a full access, even if its address is sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_addr | input | AW | Byte address of the requested halfword |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| cfg_en | input | 1 | Burst mode enable |
| cfg_run8 | input | 1 | Group size: 0 = 4 words, 1 = 8 words |
| cfg_slow_burst | input | 1 | Burst cycle: 0 = one state, 1 = two states |
| cfg_long_init | input | 1 | Initial cycle: 0 = 2 states, 1 = 3 states with waits |
| wait_n | input | 1 | Active-low wait request from the ROM |
| rdy | output | 1 | Data-valid pulse |
| rdata | output | 16 | Returned word |
| rom_addr | output | AW | ROM address (bit 0 always 0) |
| rom_cs_n | output | 1 | Active-low chip-select |
| rom_rd_n | output | 1 | Active-low read strobe |
| rom_data | input | 16 | ROM read data |

## Verification
A corrupted state counter or a wrongly latched configuration shows up at once as a ready pulse one or more cycles early or late against the arithmetic latency. If the capture timing or the held address is wrong, the first returned word after the fault carries the wrong value. A broken continuation decision shows as a chip-select-high cycle that should not be there, or one that is missing, at the first group crossing or the first data read. The fault therefore becomes visible within the same request, a few cycles after it occurs.

// File: rtl/brom_pkg.sv
package brom_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_GAP   = 3'd1,
    S_FULL  = 3'd2,
    S_BURST = 3'd3,
    S_LINK  = 3'd4
  } brom_st_t;

  typedef struct packed {
    logic en;
    logic run8;
    logic slow;
    logic lng;
  } brom_cfg_t;

  // counter preload: states minus one
  function automatic logic [1:0] full_preload(input logic lng);
    return lng ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [1:0] burst_preload(input logic slow);
    return slow ? 2'd1 : 2'd0;
  endfunction

endpackage

// File: rtl/brom_area_dec.sv
module brom_area_dec #(
  parameter int AW = 24,
  parameter logic [AW-1:0] BASE = '0,
  parameter int LG = 20
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int TW = AW - LG;
  localparam logic [TW-1:0] TAG = BASE[AW-1:LG];
  assign hit = (addr[AW-1:LG] == TAG);
endmodule

// File: rtl/brom_seq_chk.sv
module brom_seq_chk #(
  parameter int AW = 24,
  parameter int GS_LG = 3,
  parameter int GL_LG = 4
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] nxt,
  input  logic          run8,
  output logic          seq
);
  logic [AW-1:0] inc;
  logic same_s, same_l;
  assign inc    = cur + AW'(2);
  assign same_s = (nxt[AW-1:GS_LG] == cur[AW-1:GS_LG]);
  assign same_l = (nxt[AW-1:GL_LG] == cur[AW-1:GL_LG]);
  assign seq    = (nxt[AW-1:1] == inc[AW-1:1]) && (run8 ? same_l : same_s);
endmodule

// File: rtl/brom_timer.sv
module brom_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          active,
  input  logic          stretch,
  input  logic          wait_n,
  output logic          last,
  output logic          cap
);
  logic [CW-1:0] cnt;
  assign last = (cnt == '0);
  assign cap  = active && last && !(stretch && !wait_n);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (active && !last)  cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/brom_ctrl.sv
module brom_ctrl
  import brom_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] AREA_BASE = '0,
  parameter int AREA_LG = 20,
  parameter int WORDS_S = 4,
  parameter int WORDS_L = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_fetch,
  input  logic          cfg_en,
  input  logic          cfg_run8,
  input  logic          cfg_slow_burst,
  input  logic          cfg_long_init,
  input  logic          wait_n,
  output logic          rdy,
  output logic [15:0]   rdata,
  output logic [AW-1:0] rom_addr,
  output logic          rom_cs_n,
  output logic          rom_rd_n,
  input  logic [15:0]   rom_data
);
  localparam int GS_LG = $clog2(WORDS_S * 2);
  localparam int GL_LG = $clog2(WORDS_L * 2);

  brom_st_t      st, st_nx;
  brom_cfg_t     cfg_in, cfg_q;
  logic [AW-1:0] cur_addr;
  logic          cur_fetch;
  logic          rdy_q;
  logic [15:0]   rdata_q;

  logic area_hit, seq_ok, cont;
  logic take, latch_cfg;
  logic t_load, t_last, t_cap, t_active, t_stretch;
  logic [1:0] t_val;

  // observation wires for the checker
  logic burst_last, short_full_last, in_burst, idle_st;

  assign cfg_in = '{en: cfg_en, run8: cfg_run8, slow: cfg_slow_burst, lng: cfg_long_init};

  brom_area_dec #(.AW(AW), .BASE(AREA_BASE), .LG(AREA_LG)) u_dec (
    .addr(req_addr), .hit(area_hit)
  );

  brom_seq_chk #(.AW(AW), .GS_LG(GS_LG), .GL_LG(GL_LG)) u_seq (
    .cur(cur_addr), .nxt(req_addr), .run8(cfg_q.run8), .seq(seq_ok)
  );

  assign t_active  = (st == S_FULL) || (st == S_BURST);
  assign t_stretch = (st == S_FULL) && cfg_q.lng;

  brom_timer #(.CW(2)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .active(t_active), .stretch(t_stretch), .wait_n(wait_n),
    .last(t_last), .cap(t_cap)
  );

  assign cont = cfg_q.en && req_fetch && cur_fetch && seq_ok;

  always_comb begin
    st_nx     = st;
    take      = 1'b0;
    latch_cfg = 1'b0;
    t_load    = 1'b0;
    t_val     = 2'd0;
    case (st)
      S_IDLE: if (req_valid && area_hit) begin
        st_nx = S_FULL; take = 1'b1; latch_cfg = 1'b1;
        t_load = 1'b1; t_val = full_preload(cfg_long_init);
      end
      S_GAP: begin
        st_nx = S_FULL; latch_cfg = 1'b1;
        t_load = 1'b1; t_val = full_preload(cfg_long_init);
      end
      S_FULL, S_BURST: if (t_cap) st_nx = S_LINK;
      S_LINK: begin
        if (req_valid && area_hit) begin
          take = 1'b1;
          if (cont) begin
            st_nx = S_BURST; t_load = 1'b1; t_val = burst_preload(cfg_q.slow);
          end else begin
            st_nx = S_GAP;
          end
        end else begin
          st_nx = S_IDLE;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cfg_q     <= '0;
      cur_addr  <= '0;
      cur_fetch <= 1'b0;
      rdy_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      st    <= st_nx;
      rdy_q <= t_cap;
      if (t_cap)     rdata_q <= rom_data;
      if (latch_cfg) cfg_q   <= cfg_in;
      if (take) begin
        cur_addr  <= {req_addr[AW-1:1], 1'b0};
        cur_fetch <= req_fetch;
      end
    end
  end

  assign rdy      = rdy_q;
  assign rdata    = rdata_q;
  assign rom_addr = cur_addr;
  assign rom_cs_n = !((st == S_FULL) || (st == S_BURST) || (st == S_LINK));
  assign rom_rd_n = (st == S_IDLE) || (st == S_GAP);

  assign burst_last      = (st == S_BURST) && t_last;
  assign short_full_last = (st == S_FULL) && t_last && !cfg_q.lng;
  assign in_burst        = (st == S_BURST);
  assign idle_st         = (st == S_IDLE);

endmodule

// File: rtl/brom_ctrl_chk.sv
module brom_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       area_hit,
  input logic       rdy,
  input logic       rom_cs_n,
  input logic       rom_rd_n,
  input logic       cap_evt,
  input logic       burst_last,
  input logic       short_full_last,
  input logic       in_burst,
  input logic       idle_st,
  input logic [3:0] cfg_bits
);
  // R9
  rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rdy |=> !rdy);
  // R9
  cap_to_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n) cap_evt |=> rdy);
  // R7
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) rom_rd_n == rom_cs_n);
  // R7
  rdy_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n) rdy |-> !rom_cs_n);
  // R5
  burst_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n) burst_last |-> cap_evt);
  // R2
  short_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n) short_full_last |-> cap_evt);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (in_burst && $past(in_burst)) |-> $stable(cfg_bits));
  // R10
  miss_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_st && req_valid && !area_hit) |=> rom_cs_n);
endmodule

bind brom_ctrl brom_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .area_hit(area_hit),
  .rdy(rdy), .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .cap_evt(t_cap),
  .burst_last(burst_last), .short_full_last(short_full_last),
  .in_burst(in_burst), .idle_st(idle_st), .cfg_bits(cfg_q)
);

// File: tb/sim_brom_ctrl.sv
module sim_brom_ctrl;
  localparam int AW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_fetch = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic cfg_en = 0, cfg_run8 = 0, cfg_slow_burst = 0, cfg_long_init = 0;
  logic wait_n = 1'b1;
  logic rdy, rom_cs_n, rom_rd_n;
  logic [15:0] rdata, rom_data;
  logic [AW-1:0] rom_addr;

  int tests = 0, fails = 0, wlow = 0, last_lat = 0;
  bit done = 0;
  // bench model of the latched run configuration
  bit m_en, m_r8, m_slow, p_fetch;
  logic [AW-1:0] p_addr;

  always #5 clk = ~clk;

  function automatic logic [15:0] rom_fn(input logic [AW-1:0] a);
    return (a[15:0] ^ 16'hA5C3) + {8'h00, a[23:16]} + 16'd7;
  endfunction

  assign rom_data = (!rom_cs_n && !rom_rd_n) ? rom_fn(rom_addr) : 16'hFFFF;

  brom_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_fetch(req_fetch), .cfg_en(cfg_en), .cfg_run8(cfg_run8),
    .cfg_slow_burst(cfg_slow_burst), .cfg_long_init(cfg_long_init),
    .wait_n(wait_n), .rdy(rdy), .rdata(rdata), .rom_addr(rom_addr),
    .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .rom_data(rom_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_wait();
    wait_n = (wlow == 0);
    if (wlow > 0) wlow--;
  endtask

  // called right after a negedge; b2b = issued in the ready cycle
  task automatic issue(input logic [AW-1:0] a, input bit f, input int w, input bit b2b);
    bit cont;
    int t, lat, gaps, cyc, hi;
    string tag;
    cont = b2b && m_en && f && p_fetch && (a == p_addr + 2) && ((a % (m_r8 ? 16 : 8)) != 0);
    if (cont) begin
      lat = m_slow ? 3 : 2; gaps = 0; wlow = 3; tag = "R3 R4 R5";
    end else begin
      m_en = cfg_en; m_r8 = cfg_run8; m_slow = cfg_slow_burst;
      t = cfg_long_init ? 3 : 2;
      if (b2b) begin
        lat = t + 2; gaps = 1; wlow = t + w; tag = "R6 R4";
      end else begin
        lat = t + 1; gaps = 0; wlow = t - 1 + w; tag = "R1 R11";
      end
      if (cfg_long_init) lat += w;
      if (w > 0) tag = {tag, " R2"};
    end
    req_valid = 1; req_addr = a; req_fetch = f;
    cyc = 0; hi = 0;
    do begin
      @(negedge clk);
      req_valid = 0;
      step_wait();
      cyc++;
      if (rom_cs_n) hi++;
    end while (!rdy && cyc < 20);
    last_lat = cyc;
    chk(cyc == lat, {tag, " latency"}, cyc, lat);
    chk(rdata == rom_fn({a[AW-1:1], 1'b0}), "R1 data", rdata, rom_fn({a[AW-1:1], 1'b0}));
    chk(hi == gaps, "R7 chip-select gap count", hi, gaps);
    p_addr = a; p_fetch = f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_wait();
      chk(rom_cs_n && rom_rd_n && !rdy, "R7 R9 idle strobes", {rom_cs_n, rom_rd_n, rdy}, 3'b110);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rom_cs_n && rom_rd_n && !rdy, "R7 reset state", {rom_cs_n, rom_rd_n, rdy}, 3'b110);
    rst_n = 1;
    @(negedge clk);

    // sweep every configuration over a run that crosses both group sizes
    for (int c = 0; c < 16; c++) begin
      logic [AW-1:0] base;
      {cfg_en, cfg_run8, cfg_slow_burst, cfg_long_init} = 4'(c);
      base = 24'h001004 + AW'(c * 64);
      idle(2);
      for (int i = 0; i < 10; i++) issue(base + AW'(2 * i), 1'b1, i % 3, i != 0);
      issue(base + 24'd20, 1'b0, 1, 1'b1);        // data read in ready cycle (R6)
      issue(base + 24'd22, 1'b1, 0, 1'b1);
      issue(base + 24'd30, 1'b1, 2, 1'b1);        // non-sequential (R6)
      idle(2);
      issue(base + 24'd32, 1'b1, 0, 1'b0);        // sequential after idle (R11)
    end

    // configuration change inside a burst (R8)
    {cfg_en, cfg_run8, cfg_slow_burst, cfg_long_init} = 4'b1100;
    idle(2);
    issue(24'h003000, 1'b1, 0, 1'b0);
    {cfg_en, cfg_run8, cfg_slow_burst, cfg_long_init} = 4'b1011;
    issue(24'h003002, 1'b1, 0, 1'b1);
    chk(last_lat == 2, "R8 burst length held", last_lat, 2);
    for (int i = 2; i < 8; i++) issue(24'h003000 + AW'(2 * i), 1'b1, 0, 1'b1);
    chk(last_lat == 2, "R8 group size held", last_lat, 2);
    issue(24'h003010, 1'b1, 1, 1'b1);
    chk(last_lat == 6, "R8 new config at next full access", last_lat, 6);

    // request outside the area (R10)
    idle(2);
    begin
      int bad = 0;
      req_valid = 1; req_addr = 24'h100000; req_fetch = 1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        req_valid = 0;
        if (rdy || !rom_cs_n) bad++;
      end
      chk(bad == 0, "R10 outside request ignored", bad, 0);
    end
    issue(24'h000400, 1'b1, 0, 1'b0);
    idle(1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule